// File: doc/BRIEF.md
# Flash Read Page Buffer

This block sits between a CPU read port and the read port of a flash array. It holds a small set of page buffers. Each buffer stores one whole flash page, the page address as a tag, and a valid flag. Every CPU read compares the requested address with the tags of the valid buffers.

On a match, the requested word comes straight from the buffer in the same clock. On a mismatch, the block does four things in order:
- it drops the least recently used buffer;
- it asks the array for the missing page;
- it returns the word while the page arrives in the second clock;
- at the end of that clock it keeps the page, with its tag and a set valid flag.

The CPU holds its request, address and byte enables steady until it sees an acknowledge. The flash array answers a page request with the full page one cycle later. A flush input empties the buffers whenever the array contents may have changed.

Top module: `flash_page_rd`

## Requirements
- R1: After reset no buffer holds a page, so the first read of any address takes the two-clock refill path.
- R2: A read whose page is buffered is acknowledged in the same clock in which it is presented, and issues no array request.
- R3: A read whose page is not buffered raises `arr_req_o` with `arr_page_o` equal to `addr_i[15:4]` in its first clock, with `ack_o` low. It is acknowledged in the second clock.
- R4: The returned word is word `addr_i[3:2]` of the page, where word w occupies bits `32*w+31:32*w` of the 128-bit page. On a refill this is the word just delivered on `arr_data_i`.
- R5: After a refill completes, any word of that page is read as a one-clock hit.
- R6: Byte b of `rdata_o` (bits `8*b+7:8*b`) carries the selected byte when `be_i[b]` is 1, and is zero when `be_i[b]` is 0.
- R7: On a miss the least recently used buffer is replaced, where both hits and refills count as use. The other buffered page stays readable in one clock.
- R8: A `flush_i` pulse leaves every buffer invalid, so that every page read afterwards takes two clocks.
- R9: A flush during the refill clock still lets that read complete with the fetched word. The page is then not kept, and reading it again takes two clocks.
- R10: Address bits `addr_i[1:0]` are ignored: they change neither the data returned nor the hit decision.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| flush_i | input | 1 | Invalidate all buffers |
| req_i | input | 1 | CPU read request, held until acknowledged |
| addr_i | input | 16 | CPU byte address |
| be_i | input | 4 | Byte enables for the returned word |
| ack_o | output | 1 | Read complete, `rdata_o` valid |
| rdata_o | output | 32 | Read data, with disabled bytes zeroed |
| arr_req_o | output | 1 | Page fetch request to the array |
| arr_page_o | output | 12 | Page address of the fetch |
| arr_data_i | input | 128 | Page data, valid one cycle after the request |

## Verification
The bench counts the clocks of every read, so a design that completes a refill in one clock or stalls a hit for a second clock shows up as a cycle-count mismatch. The replacement sequence hits page A between two misses. A design that replaced the oldest-filled buffer rather than the least recently used one would evict A, and A's next read would take two clocks. A flush raised in the middle of a refill catches a design that keeps the page anyway, because it would answer the next read as a hit. A design that drops the read instead would fail to acknowledge. Reads with partial and empty byte enables, and with nonzero low address bits, catch byte-lane and word-select errors in both the buffered path and the bypass path.

// File: rtl/fpb_pkg.sv
package fpb_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_FILL = 1'b1
  } fpb_state_e;
endpackage

// File: rtl/fpb_tags.sv
module fpb_tags #(
  parameter int N_BUF = 2,
  parameter int TAG_W = 12,
  localparam int IDX_W = $clog2(N_BUF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [TAG_W-1:0] lookup_tag_i,
  input  logic             inval_en_i,
  input  logic [IDX_W-1:0] inval_idx_i,
  input  logic             load_en_i,
  input  logic [IDX_W-1:0] load_idx_i,
  input  logic [TAG_W-1:0] load_tag_i,
  output logic [N_BUF-1:0] hit_vec_o,
  output logic             hit_o,
  output logic [IDX_W-1:0] hit_idx_o
);
  logic [N_BUF-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [N_BUF];

  for (genvar i = 0; i < N_BUF; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[i] <= 1'b0;
        tag_q[i]   <= '0;
      end else if (flush_i) begin
        valid_q[i] <= 1'b0;
      end else if (load_en_i && load_idx_i == IDX_W'(i)) begin
        valid_q[i] <= 1'b1;
        tag_q[i]   <= load_tag_i;
      end else if (inval_en_i && inval_idx_i == IDX_W'(i)) begin
        valid_q[i] <= 1'b0;
      end
    end
    assign hit_vec_o[i] = valid_q[i] && (tag_q[i] == lookup_tag_i);
  end

  always_comb begin
    hit_idx_o = '0;
    for (int i = 0; i < N_BUF; i++) begin
      if (hit_vec_o[i]) hit_idx_o = IDX_W'(i);
    end
  end
  assign hit_o = |hit_vec_o;

  // R2: at most one buffer matches a lookup
  p_single_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_vec_o));
  // R5: a completed load leaves the entry valid
  p_load_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_en_i && !flush_i) |=> valid_q[$past(load_idx_i)]);
  // R8: flush empties every entry
  p_flush_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (valid_q == '0));
endmodule

// File: rtl/fpb_lru.sv
module fpb_lru #(
  parameter int N_BUF = 2,
  localparam int IDX_W = $clog2(N_BUF)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             touch_en_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  output logic [IDX_W-1:0] victim_idx_o
);
  // age 0 = most recent, N_BUF-1 = victim; ages stay a permutation
  logic [IDX_W-1:0] age_q [N_BUF];
  logic [N_BUF-1:0] oldest_vec;

  for (genvar i = 0; i < N_BUF; i++) begin : g_age
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        age_q[i] <= IDX_W'(N_BUF - 1 - i);
      end else if (touch_en_i) begin
        if (touch_idx_i == IDX_W'(i))          age_q[i] <= '0;
        else if (age_q[i] < age_q[touch_idx_i]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
    assign oldest_vec[i] = (age_q[i] == IDX_W'(N_BUF - 1));
  end

  always_comb begin
    victim_idx_o = '0;
    for (int i = 0; i < N_BUF; i++) begin
      if (oldest_vec[i]) victim_idx_o = IDX_W'(i);
    end
  end

  // R7: exactly one replacement candidate
  p_one_victim_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot(oldest_vec));
  // R7: a touched entry is never the next victim
  p_touch_not_victim_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_en_i |=> (victim_idx_o != $past(touch_idx_i)));
endmodule

// File: rtl/fpb_store.sv
module fpb_store #(
  parameter int N_BUF  = 2,
  parameter int PAGE_W = 128,
  localparam int IDX_W = $clog2(N_BUF)
) (
  input  logic              clk_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [PAGE_W-1:0] wr_page_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [PAGE_W-1:0] rd_page_o
);
  logic [PAGE_W-1:0] page_q [N_BUF];

  for (genvar i = 0; i < N_BUF; i++) begin : g_pg
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_idx_i == IDX_W'(i)) page_q[i] <= wr_page_i;
    end
  end
  assign rd_page_o = page_q[rd_idx_i];
endmodule

// File: rtl/flash_page_rd.sv
module flash_page_rd #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 16,
  parameter int N_BUF      = 2,
  parameter int DATA_W     = 32,
  localparam int OFF_W  = $clog2(PAGE_BYTES),
  localparam int TAG_W  = ADDR_W - OFF_W,
  localparam int PAGE_W = PAGE_BYTES * 8,
  localparam int BE_W   = DATA_W / 8,
  localparam int LANE_W = $clog2(BE_W),
  localparam int WSEL_W = OFF_W - LANE_W,
  localparam int IDX_W  = $clog2(N_BUF)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BE_W-1:0]   be_i,
  output logic              ack_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              arr_req_o,
  output logic [TAG_W-1:0]  arr_page_o,
  input  logic [PAGE_W-1:0] arr_data_i
);
  import fpb_pkg::*;

  fpb_state_e       state_q;
  logic [IDX_W-1:0] fill_idx_q;
  logic [TAG_W-1:0] fill_tag_q;

  logic [TAG_W-1:0] req_tag;
  logic [WSEL_W-1:0] wsel;
  logic [N_BUF-1:0] hit_vec;
  logic             hit;
  logic [IDX_W-1:0] hit_idx, victim_idx;
  logic             idle_hit, idle_miss, filling;
  logic             touch_en;
  logic [IDX_W-1:0] touch_idx;
  logic [PAGE_W-1:0] buf_page, src_page;
  logic [DATA_W-1:0] word;
  logic             unused_lane;

  assign req_tag     = addr_i[ADDR_W-1:OFF_W];
  assign wsel        = addr_i[OFF_W-1:LANE_W];
  assign unused_lane = ^addr_i[LANE_W-1:0];

  assign filling   = (state_q == ST_FILL);
  assign idle_hit  = !filling && req_i && hit;
  assign idle_miss = !filling && req_i && !hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      fill_idx_q <= '0;
      fill_tag_q <= '0;
    end else if (idle_miss) begin
      state_q    <= ST_FILL;
      fill_idx_q <= victim_idx;
      fill_tag_q <= req_tag;
    end else if (filling) begin
      state_q <= ST_IDLE;
    end
  end

  fpb_tags #(.N_BUF(N_BUF), .TAG_W(TAG_W)) u_tags (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush_i),
    .lookup_tag_i(req_tag),
    .inval_en_i  (idle_miss),
    .inval_idx_i (victim_idx),
    .load_en_i   (filling),
    .load_idx_i  (fill_idx_q),
    .load_tag_i  (fill_tag_q),
    .hit_vec_o   (hit_vec),
    .hit_o       (hit),
    .hit_idx_o   (hit_idx)
  );

  assign touch_en  = idle_hit || filling;
  assign touch_idx = filling ? fill_idx_q : hit_idx;

  fpb_lru #(.N_BUF(N_BUF)) u_lru (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .touch_en_i  (touch_en),
    .touch_idx_i (touch_idx),
    .victim_idx_o(victim_idx)
  );

  fpb_store #(.N_BUF(N_BUF), .PAGE_W(PAGE_W)) u_store (
    .clk_i    (clk_i),
    .wr_en_i  (filling),
    .wr_idx_i (fill_idx_q),
    .wr_page_i(arr_data_i),
    .rd_idx_i (hit_idx),
    .rd_page_o(buf_page)
  );

  // refill word bypasses the buffer so the miss ends in clock two
  assign src_page = filling ? arr_data_i : buf_page;
  assign word     = src_page[wsel*DATA_W +: DATA_W];

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign rdata_o[8*b +: 8] = be_i[b] ? word[8*b +: 8] : 8'h00;
  end

  assign ack_o      = idle_hit || filling;
  assign arr_req_o  = idle_miss;
  assign arr_page_o = req_tag;

  // R2: hit completes in the clock it is presented, no fetch
  p_hit_one_clk_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!filling && req_i && hit) |-> (ack_o && !arr_req_o));
  // R3: fetch clock never acknowledges
  p_miss_no_ack_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_req_o |-> !ack_o);
  // R3: fetch is always followed by completion in the next clock
  p_miss_two_clk_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arr_req_o |=> (ack_o && !arr_req_o));
  // R6: no enabled lane means an all-zero word
  p_be_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_o && be_i == '0) |-> (rdata_o == '0));
endmodule

// File: tb/sim_flash_page_rd.sv
module sim_flash_page_rd;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         flush = 1'b0;
  logic         req = 1'b0;
  logic [15:0]  addr = '0;
  logic [3:0]   be = '0;
  logic         ack;
  logic [31:0]  rdata;
  logic         arr_req;
  logic [11:0]  arr_page;
  logic [127:0] arr_data = '0;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_page_rd u0 (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .req_i(req),
    .addr_i(addr), .be_i(be), .ack_o(ack), .rdata_o(rdata),
    .arr_req_o(arr_req), .arr_page_o(arr_page), .arr_data_i(arr_data)
  );

  function automatic logic [31:0] pg_word(input logic [11:0] pg, input int w);
    return {pg, 4'(w), ~pg[7:0], 8'(w * 17 + 3)};
  endfunction

  function automatic logic [127:0] pg_data(input logic [11:0] pg);
    logic [127:0] d;
    for (int w = 0; w < 4; w++) d[32*w +: 32] = pg_word(pg, w);
    return d;
  endfunction

  function automatic logic [31:0] masked(input logic [31:0] v, input logic [3:0] m);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = m[b] ? v[8*b +: 8] : 8'h00;
    return r;
  endfunction

  // array model: page one cycle after request
  always_ff @(posedge clk) if (arr_req) arr_data <= pg_data(arr_page);

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic rd(input logic [15:0] a, input logic [3:0] m, input int exp_cyc, input string rq);
    int cyc = 0;
    logic [31:0] exp_d = masked(pg_word(a[15:4], int'(a[3:2])), m);
    @(negedge clk);
    req = 1'b1; addr = a; be = m;
    forever begin
      #1;
      cyc++;
      if (cyc == 1) begin
        if (exp_cyc == 1) chk(!arr_req, {rq, " no fetch on hit"}, 32'(arr_req), 0);
        else chk(arr_req && !ack && arr_page == a[15:4], {rq, " fetch page"},
                 {19'(0), arr_req, arr_page}, {20'h00001, a[15:4]});
      end
      if (ack || cyc >= 4) break;
      @(negedge clk);
    end
    chk(cyc == exp_cyc, {rq, " cycles"}, 32'(cyc), 32'(exp_cyc));
    chk(rdata == exp_d, {rq, " data"}, rdata, exp_d);
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(posedge clk); #1; flush = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); #1;
    chk(!ack && !arr_req, "R1 idle outputs", {30'(0), ack, arr_req}, 0);
    rd(16'h0100, 4'hF, 2, "R1 R3 R4 first read");
  endtask

  task automatic t_hit();
    rd(16'h0108, 4'hF, 1, "R2 R5 hit word2");
    rd(16'h010C, 4'hF, 1, "R5 R4 hit word3");
    rd(16'h0100, 4'hF, 1, "R2 hit word0");
  endtask

  task automatic t_bytes();
    rd(16'h0104, 4'b0101, 1, "R6 lanes 0,2");
    rd(16'h0104, 4'b0000, 1, "R6 no lanes");
    rd(16'h0224, 4'b1000, 2, "R6 R4 miss lane3");
  endtask

  task automatic t_low_bits();
    rd(16'h0107, 4'hF, 1, "R10 low bits hit");
    rd(16'h0332, 4'hF, 2, "R10 low bits miss");
    rd(16'h0330, 4'hF, 1, "R10 same word");
  endtask

  task automatic t_lru();
    do_flush();
    rd(16'h0A00, 4'hF, 2, "R7 fill A");
    rd(16'h0B00, 4'hF, 2, "R7 fill B");
    rd(16'h0A04, 4'hF, 1, "R7 hit A");
    rd(16'h0C00, 4'hF, 2, "R7 fill C evicts B");
    rd(16'h0A08, 4'hF, 1, "R7 A kept");
    rd(16'h0C04, 4'hF, 1, "R7 C kept");
    rd(16'h0B04, 4'hF, 2, "R7 B evicted");
    rd(16'h0C08, 4'hF, 1, "R7 C kept after refill");
  endtask

  task automatic t_flush();
    do_flush();
    rd(16'h0C00, 4'hF, 2, "R8 C after flush");
    rd(16'h0B00, 4'hF, 2, "R8 B after flush");
  endtask

  task automatic t_flush_fill();
    logic [31:0] exp_d = pg_word(12'h0D0, 1);
    @(negedge clk);
    req = 1'b1; addr = 16'h0D04; be = 4'hF;
    #1;
    chk(arr_req && !ack, "R9 fetch starts", {30'(0), arr_req, ack}, 32'h2);
    @(negedge clk);
    flush = 1'b1;
    #1;
    chk(ack, "R9 ack under flush", 32'(ack), 1);
    chk(rdata == exp_d, "R9 data under flush", rdata, exp_d);
    @(posedge clk); #1;
    flush = 1'b0; req = 1'b0;
    rd(16'h0D04, 4'hF, 2, "R9 page not kept");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_hit();
    t_bytes();
    t_low_bits();
    t_lru();
    t_flush();
    t_flush_fill();
    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule